// File: doc/BRIEF.md
# Programmable Video Sync Repositioning Generator

This block rebuilds the horizontal and vertical sync outputs of a video decoder so that their placement is set by software. It watches an active-low incoming horizontal sync and a field identity bit. The output HS is placed by two 11-bit pixel offsets counted from the falling edge of the incoming sync. The output VS is placed on programmed line numbers within each field. Each VS edge lands either at the start of its line or at half a line. The start/half choice is made separately for each field and for each edge, or a fixed legacy placement is used instead.

Control fields are loaded through a small write port into shadow registers. They are copied into the working set only on a falling edge of the incoming sync, so a write never changes the line in progress. Both outputs are registered on the pixel clock.

Top module: `sync_reposition_gen`

## Requirements
- R1: After synchronous reset both `hs_out` and `vs_out` are low and every control field is zero. With all-zero fields, neither output pulses.
- R2: `hs_out` goes high at the clock edge that comes HB clocks after the edge that first samples `hsync_in` low. HB is the 11-bit begin offset: bits 7:0 at address 0 and bits 10:8 from `wr_data[2:0]` at address 1.
- R3: `hs_out` goes low HE clocks after that same edge. HE is the 11-bit end offset: bits 7:0 at address 2 and bits 10:8 from `wr_data[2:0]` at address 3. When HB equals HE, no HS pulse is produced.
- R4: The upper three bits of HB and HE take part in placement, so offsets above 255 are honoured.
- R5: When HE is less than HB, the HS pulse rises at HB, runs across the line boundary, and falls at HE on the next line.
- R6: Written values take effect at the next falling edge of `hsync_in`. A write in mid-line leaves the rest of that line unchanged.
- R7: Address 4 is the VS mode register; bit 0 selects manual placement. When bit 0 is 0, VS edges in the even field (`field_in`=0) fall at line start and VS edges in the odd field fall at mid-line, and bits 2 to 5 have no effect.
- R8: In manual mode the VS rising edge is at line start when the field's bit is 1 and at mid-line when it is 0. The even field uses address 4 bit 2 and the odd field uses bit 3.
- R9: In manual mode the VS falling edge is at line start when the field's bit is 1 and at mid-line when it is 0. The even field uses address 4 bit 4 and the odd field uses bit 5.
- R10: Address 4 bit 1 sets the line start for VS. With 1, line start is the falling edge of `hsync_in`. With 0, line start is the edge that first samples `hsync_in` high again.
- R11: Mid-line is the clock that comes half the programmed line total after line start. The 12-bit line total is set by address 5 (bits 7:0) and address 6 (`wr_data[3:0]` as bits 11:8).
- R12: Lines are numbered from 0 starting at the first line start at which `field_in` differs from the stored field. VS rises on the line set at address 7 and falls on the line set at address 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Incoming horizontal sync, active low |
| field_in | input | 1 | Field identity, 0 even, 1 odd |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| hs_out | output | 1 | Regenerated horizontal sync |
| vs_out | output | 1 | Regenerated vertical sync |

## Verification
Each output edge is due at the very clock edge whose pixel count from the reference equals the programmed offset. There is no extra pipeline stage, so an offset of N shows on the outputs just after the N-th edge following the sync fall. The bench drives one pixel per clock and samples just after each rising edge. It records the pixel index, and for VS also the line index, at which each output changes, then compares those indices against the programmed values. With the line-end reference, the expected positions are shifted by the sync width. For the mid-line write check, the first HS rise is compared against the old offset and the rise on the following line against the new one.

// File: rtl/sync_rp_pkg.sv
package sync_rp_pkg;
    localparam int HPOS_W = 11;
    localparam int CNT_W  = 12;
    localparam int LINE_W = 8;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int HPOS_HI_W = HPOS_W - DATA_W;
    localparam int CNT_HI_W  = CNT_W - DATA_W;

    typedef enum logic [ADDR_W-1:0] {
        A_HB_LO  = 4'd0,
        A_HB_HI  = 4'd1,
        A_HE_LO  = 4'd2,
        A_HE_HI  = 4'd3,
        A_MODE   = 4'd4,
        A_TOT_LO = 4'd5,
        A_TOT_HI = 4'd6,
        A_VON    = 4'd7,
        A_VOFF   = 4'd8
    } reg_addr_e;

    // bit 0 is the last member of the packed struct
    typedef struct packed {
        logic fall_start_odd;
        logic fall_start_even;
        logic rise_start_odd;
        logic rise_start_even;
        logic ref_lead;
        logic manual;
    } vs_mode_t;

    typedef struct packed {
        logic [HPOS_W-1:0] hs_begin;
        logic [HPOS_W-1:0] hs_end;
        logic [CNT_W-1:0]  line_total;
        logic [LINE_W-1:0] vs_on_line;
        logic [LINE_W-1:0] vs_off_line;
        vs_mode_t          mode;
    } sync_cfg_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    // 1: place the edge at line start, 0: place it at mid-line
    function automatic logic edge_at_start(input vs_mode_t m, input logic odd, input logic rising);
        if (!m.manual) return !odd;
        if (rising) return odd ? m.rise_start_odd : m.rise_start_even;
        return odd ? m.fall_start_odd : m.fall_start_even;
    endfunction
endpackage

// File: rtl/sync_rp_regs.sv
module sync_rp_regs
    import sync_rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output sync_cfg_t         cfg_next
);
    sync_cfg_t shadow_q;
    sync_cfg_t active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_en) begin
                case (reg_addr_e'(wr_addr))
                    A_HB_LO:  shadow_q.hs_begin[DATA_W-1:0]      <= wr_data;
                    A_HB_HI:  shadow_q.hs_begin[HPOS_W-1:DATA_W] <= wr_data[HPOS_HI_W-1:0];
                    A_HE_LO:  shadow_q.hs_end[DATA_W-1:0]        <= wr_data;
                    A_HE_HI:  shadow_q.hs_end[HPOS_W-1:DATA_W]   <= wr_data[HPOS_HI_W-1:0];
                    A_MODE:   shadow_q.mode                      <= vs_mode_t'(wr_data[$bits(vs_mode_t)-1:0]);
                    A_TOT_LO: shadow_q.line_total[DATA_W-1:0]    <= wr_data;
                    A_TOT_HI: shadow_q.line_total[CNT_W-1:DATA_W] <= wr_data[CNT_HI_W-1:0];
                    A_VON:    shadow_q.vs_on_line                <= wr_data[LINE_W-1:0];
                    A_VOFF:   shadow_q.vs_off_line               <= wr_data[LINE_W-1:0];
                    default: ;
                endcase
            end
            if (load) active_q <= shadow_q;
        end
    end

    assign cfg_next = load ? shadow_q : active_q;

    // R6: working set only moves on a sync falling edge
    assert_hold_midline_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active_q));
endmodule

// File: rtl/sync_rp_hs.sv
module sync_rp_hs
    import sync_rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_fall,
    input  logic [HPOS_W-1:0] hs_begin,
    input  logic [HPOS_W-1:0] hs_end,
    output logic              hs_out
);
    logic [CNT_W-1:0] pix_q;
    logic [CNT_W-1:0] pix_d;
    logic             hit_begin;
    logic             hit_end;

    assign pix_d     = sync_fall ? '0 : sat_inc(pix_q);
    assign hit_begin = (pix_d == CNT_W'(hs_begin));
    assign hit_end   = (pix_d == CNT_W'(hs_end));

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q  <= '0;
            hs_out <= 1'b0;
        end else begin
            pix_q <= pix_d;
            if (hit_end)        hs_out <= 1'b0;
            else if (hit_begin) hs_out <= 1'b1;
        end
    end

    // R2: a rising HS sits at the programmed begin offset
    assert_hs_rise_pos_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_out) |-> (pix_q == CNT_W'($past(hs_begin))));
    // R3: a falling HS sits at the programmed end offset
    assert_hs_fall_pos_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(hs_out) |-> (pix_q == CNT_W'($past(hs_end))));
endmodule

// File: rtl/sync_rp_vs.sv
module sync_rp_vs
    import sync_rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              field_in,
    input  logic [CNT_W-1:0]  line_total,
    input  logic [LINE_W-1:0] on_line,
    input  logic [LINE_W-1:0] off_line,
    input  vs_mode_t          mode,
    output logic              vs_out
);
    logic [CNT_W-1:0]  vpix_q, vpix_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic              fld_q, fld_d;
    logic              new_field;
    logic [CNT_W-1:0]  half;
    logic              at_mid;
    logic              rise_pt, fall_pt;
    logic              rise_hit, fall_hit;

    assign half      = line_total >> 1;
    assign vpix_d    = line_start ? '0 : sat_inc(vpix_q);
    assign new_field = line_start && (field_in != fld_q);
    assign fld_d     = line_start ? field_in : fld_q;

    always_comb begin
        line_d = line_q;
        if (new_field)       line_d = '0;
        else if (line_start) line_d = (&line_q) ? line_q : line_q + 1'b1;
    end

    assign at_mid   = (vpix_d == half);
    assign rise_pt  = edge_at_start(mode, fld_d, 1'b1) ? line_start : at_mid;
    assign fall_pt  = edge_at_start(mode, fld_d, 1'b0) ? line_start : at_mid;
    assign rise_hit = rise_pt && (line_d == on_line);
    assign fall_hit = fall_pt && (line_d == off_line);

    always_ff @(posedge clk) begin
        if (rst) begin
            vpix_q <= '0;
            line_q <= '0;
            fld_q  <= 1'b0;
            vs_out <= 1'b0;
        end else begin
            vpix_q <= vpix_d;
            line_q <= line_d;
            fld_q  <= fld_d;
            if (fall_hit)      vs_out <= 1'b0;
            else if (rise_hit) vs_out <= 1'b1;
        end
    end

    // R12: VS rises only on the programmed line
    assert_vs_rise_line_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(vs_out) |-> (line_q == $past(on_line)));
    // R11: VS edges land at line start or at half the line total
    assert_vs_edge_pos_R11: assert property (@(posedge clk) disable iff (rst)
        $changed(vs_out) |-> ((vpix_q == '0) || (vpix_q == $past(half))));
    // R7: legacy placement puts even-field edges at line start
    assert_legacy_even_R7: assert property (@(posedge clk) disable iff (rst)
        ($changed(vs_out) && !$past(mode.manual) && !fld_q) |-> (vpix_q == '0));
endmodule

// File: rtl/sync_reposition_gen.sv
module sync_reposition_gen
    import sync_rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_in,
    input  logic              field_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hs_out,
    output logic              vs_out
);
    logic      hsync_q;
    logic      sync_fall;
    logic      sync_rise;
    logic      line_start;
    sync_cfg_t cfg;

    always_ff @(posedge clk) begin
        if (rst) hsync_q <= 1'b1;
        else     hsync_q <= hsync_in;
    end

    assign sync_fall  = hsync_q && !hsync_in;
    assign sync_rise  = !hsync_q && hsync_in;
    assign line_start = cfg.mode.ref_lead ? sync_fall : sync_rise;

    sync_rp_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load     (sync_fall),
        .cfg_next (cfg)
    );

    sync_rp_hs u_hs (
        .clk       (clk),
        .rst       (rst),
        .sync_fall (sync_fall),
        .hs_begin  (cfg.hs_begin),
        .hs_end    (cfg.hs_end),
        .hs_out    (hs_out)
    );

    sync_rp_vs u_vs (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .field_in   (field_in),
        .line_total (cfg.line_total),
        .on_line    (cfg.vs_on_line),
        .off_line   (cfg.vs_off_line),
        .mode       (cfg.mode),
        .vs_out     (vs_out)
    );

    // R1: reset leaves both outputs low
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> (!hs_out && !vs_out));
endmodule

// File: tb/sync_reposition_gen_test.sv
module sync_reposition_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_in = 1'b1;
    logic       field_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       hs_out, vs_out;

    int errors = 0;
    int checks = 0;
    int hs_rise_p, hs_fall_p, vs_rise_p, vs_fall_p, vs_rise_ln, vs_fall_ln, cur_ln;
    logic hs_prev, vs_prev;
    logic pend_wr = 1'b0;
    int   pend_p = 0;
    logic [3:0] pend_a = '0;
    logic [7:0] pend_d = '0;

    always #10 clk = ~clk;

    sync_reposition_gen uut (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .field_in(field_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hs_out(hs_out), .vs_out(vs_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic run_line(input int len, input int w, input logic fld);
        hs_rise_p = -1; hs_fall_p = -1;
        hs_prev = hs_out; vs_prev = vs_out;
        for (int p = 0; p < len; p++) begin
            hsync_in = (p < w) ? 1'b0 : 1'b1;
            field_in = fld;
            wr_en = pend_wr && (p == pend_p);
            wr_addr = pend_a; wr_data = pend_d;
            @(posedge clk); #1;
            if (hs_out && !hs_prev) hs_rise_p = p;
            if (!hs_out && hs_prev) hs_fall_p = p;
            if (vs_out && !vs_prev && vs_rise_p < 0) begin vs_rise_p = p; vs_rise_ln = cur_ln; end
            if (!vs_out && vs_prev && vs_fall_p < 0) begin vs_fall_p = p; vs_fall_ln = cur_ln; end
            hs_prev = hs_out; vs_prev = vs_out;
        end
        wr_en = 1'b0; pend_wr = 1'b0;
        hsync_in = 1'b1;
        cur_ln++;
    endtask

    task automatic set_hs(input int b, input int e);
        wr(4'd0, b[7:0]); wr(4'd1, {5'd0, b[10:8]});
        wr(4'd2, e[7:0]); wr(4'd3, {5'd0, e[10:8]});
    endtask

    task automatic test_reset();
        chk("R1 hs after reset", hs_out, 0);
        chk("R1 vs after reset", vs_out, 0);
        vs_rise_p = -1; vs_fall_p = -1; cur_ln = 0;
        run_line(100, 10, 1'b0);
        run_line(100, 10, 1'b0);
        chk("R1 no hs pulse with zero fields", hs_rise_p, -1);
        chk("R1 no vs pulse with zero fields", vs_rise_p, -1);
    endtask

    task automatic test_basic();
        set_hs(20, 40);
        run_line(100, 10, 1'b0);
        run_line(100, 10, 1'b0);
        chk("R2 hs rise offset", hs_rise_p, 20);
        chk("R3 hs fall offset", hs_fall_p, 40);
        set_hs(30, 30);
        run_line(100, 10, 1'b0);
        run_line(100, 10, 1'b0);
        chk("R3 equal offsets give no pulse", hs_rise_p, -1);
    endtask

    task automatic test_upper();
        set_hs(261, 300);
        run_line(400, 10, 1'b0);
        run_line(400, 10, 1'b0);
        chk("R4 hs rise above 255", hs_rise_p, 261);
        chk("R4 hs fall above 255", hs_fall_p, 300);
    endtask

    task automatic test_wrap();
        set_hs(80, 10);
        run_line(100, 10, 1'b0);
        run_line(100, 10, 1'b0);
        run_line(100, 10, 1'b0);
        chk("R5 wrap rise", hs_rise_p, 80);
        chk("R5 wrap fall on next line", hs_fall_p, 10);
    endtask

    task automatic test_midline_write();
        set_hs(20, 40);
        run_line(100, 10, 1'b0);
        pend_wr = 1'b1; pend_p = 2; pend_a = 4'd0; pend_d = 8'd5;
        run_line(100, 10, 1'b0);
        chk("R6 line in progress keeps old begin", hs_rise_p, 20);
        run_line(100, 10, 1'b0);
        chk("R6 next line uses new begin", hs_rise_p, 5);
    endtask

    task automatic vs_field(input logic fld, input string tag,
                            input int rl, input int rp, input int fl, input int fp);
        vs_rise_p = -1; vs_fall_p = -1; vs_rise_ln = -1; vs_fall_ln = -1; cur_ln = 0;
        for (int n = 0; n < 8; n++) run_line(100, 8, fld);
        chk({tag, " rise line"}, vs_rise_ln, rl);
        chk({tag, " rise pixel"}, vs_rise_p, rp);
        chk({tag, " fall line"}, vs_fall_ln, fl);
        chk({tag, " fall pixel"}, vs_fall_p, fp);
    endtask

    task automatic test_vs_manual();
        wr(4'd5, 8'd100); wr(4'd6, 8'd0);
        wr(4'd7, 8'd2);   wr(4'd8, 8'd5);
        wr(4'd4, 8'h27);
        vs_field(1'b1, "R8 R9 R12 odd manual", 2, 50, 5, 0);
        vs_field(1'b0, "R8 R9 R11 even manual", 2, 0, 5, 50);
    endtask

    task automatic test_vs_legacy();
        wr(4'd4, 8'h26);
        vs_field(1'b1, "R7 odd legacy", 2, 50, 5, 50);
        vs_field(1'b0, "R7 even legacy ignores bits", 2, 0, 5, 0);
    endtask

    task automatic test_vs_ref_end();
        wr(4'd4, 8'h25);
        vs_field(1'b1, "R10 odd line start at sync end", 2, 58, 5, 8);
    endtask

    task automatic test_vs_total();
        wr(4'd4, 8'h27); wr(4'd5, 8'd60);
        vs_field(1'b0, "R11 even half of 60", 2, 0, 5, 30);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        test_reset();
        test_basic();
        test_upper();
        test_wrap();
        test_midline_write();
        test_vs_manual();
        test_vs_legacy();
        test_vs_ref_end();
        test_vs_total();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule